// File: doc/BRIEF.md
# Packet Framer Transmitter

This block turns one radio packet into a serial bit stream, producing at most one bit for each cycle on which the bit-rate enable is high. A packet is made of five parts, sent in this order: an alternating preamble, a sync word, an alternating trailer, payload bytes pulled from a show-ahead transmit FIFO, and an optional 16-bit CRC. The length of every header field is set at run time by a small code. The sync word is assembled from four 16-bit configuration words. Which words it uses depends on the selected length, and the selection is not contiguous.

The configuration also chooses how the payload ends. There are three policies. In the first, a length byte at the head of the payload gives the count. In the second, the packet stops as soon as the FIFO is empty at a byte boundary. In the third, the packet keeps running, sending zero filler whenever the FIFO is empty, until the host drops the transmit enable. Configuration inputs must be held stable while a packet is in flight. Modulation, line coding, error correction and whitening are handled elsewhere.

Top module: `pkt_tx_framer`

## Requirements
- R1: While reset is high and on the first cycle after it, `tx_valid`, `pkt_busy`, `pkt_done` and `fifo_rd` are all 0.
- R2: The preamble is 8*(n+1) bits for `cfg_pre_len` = n. The bits alternate and the first bit is 1.
- R3: `cfg_sync_len` codes 0, 1, 2, 3 select 16, 32, 48 and 64 sync bits. The sync vector is {W0}, {W3,W0}, {W3,W2,W0} or {W3,W2,W1,W0}, with W0 in the low bits. The vector is sent least significant bit first.
- R4: The trailer is 4+2n bits for `cfg_trl_len` = n. The bits alternate and the first bit is 1.
- R5: Each payload byte comes from `fifo_data` and is sent least significant bit first. `fifo_rd` pulses once per byte, in the cycle the byte's first bit is taken, and never while `fifo_empty` is high.
- R6: When `cfg_len_mode` is 1, the first payload byte L is sent and is followed by exactly L further bytes (L from 0 to 255). Nothing more is popped. If the FIFO is empty at a byte boundary before the packet is complete, the packet waits and sends no bits.
- R7: When `cfg_len_mode` is 0 and `cfg_auto_stop` is 1, the payload ends at the first byte boundary at which `fifo_empty` is high. This includes the very first boundary.
- R8: When `cfg_len_mode` is 0 and `cfg_auto_stop` is 0, an empty FIFO at a byte boundary sends a byte of 0x00 without popping. The payload ends at the first byte boundary at which `tx_en` is low.
- R9: When `cfg_crc_en` is 1, 16 CRC bits follow the payload, most significant bit first. The CRC uses the polynomial 0x1021 and starts from {8'h00, `cfg_crc_seed`}. It is updated with each payload bit in the order sent, length byte included, by the rule fb = crc[15]^bit; crc = (crc<<1) ^ (fb ? 0x1021 : 0). When `cfg_crc_en` is 0, no CRC bits are sent.
- R10: Every bit appears on `tx_bit` with `tx_valid` high for exactly the one cycle after a cycle in which `bit_en` was high. No bit is sent while `bit_en` stays low.
- R11: `pkt_done` is a one-cycle pulse. It arrives in the same cycle as the final CRC bit, or, with CRC off, in the cycle after the enable at which the payload ended. `pkt_busy` is high from the cycle after the start until `pkt_done`.
- R12: After `pkt_done`, no new packet starts until `tx_en` has been low for at least one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | Bit-rate enable: one bit is sent per high cycle |
| tx_en | input | 1 | Host transmit enable: starts a packet; in host-stop mode, ends it |
| cfg_pre_len | input | 3 | Preamble length code |
| cfg_sync_len | input | 2 | Sync word length code |
| cfg_trl_len | input | 3 | Trailer length code |
| cfg_sync_w0 | input | 16 | Sync configuration word W0 |
| cfg_sync_w1 | input | 16 | Sync configuration word W1 |
| cfg_sync_w2 | input | 16 | Sync configuration word W2 |
| cfg_sync_w3 | input | 16 | Sync configuration word W3 |
| cfg_len_mode | input | 1 | First payload byte carries the length |
| cfg_auto_stop | input | 1 | Stop on empty FIFO when length mode is off |
| cfg_crc_en | input | 1 | Append the 16-bit CRC |
| cfg_crc_seed | input | 8 | CRC seed, placed in the low byte |
| fifo_empty | input | 1 | Transmit FIFO has no byte |
| fifo_data | input | 8 | Head byte of the FIFO (show-ahead) |
| fifo_rd | output | 1 | Pop the head byte |
| tx_bit | output | 1 | Serial data bit |
| tx_valid | output | 1 | `tx_bit` holds a packet bit this cycle |
| pkt_busy | output | 1 | Packet in progress |
| pkt_done | output | 1 | One-cycle end-of-packet pulse |

## Verification
Each serial bit is registered once, so it is due one clock after the enable cycle that produced it. `pkt_done` shares the cycle of the final CRC bit, or, with CRC off, comes one clock after the deciding enable. `fifo_rd` is combinational and pops on the same edge as the enable that takes a byte's first bit. The bench changes inputs and samples outputs only on falling edges, so every collected bit and pulse is seen a half clock after the edge that made it. The bench records the cycle of the last valid bit and the cycle of the done pulse, so the two can be compared directly. For waiting packets, it checks that the bit count stays flat while the enable is held low or the FIFO is starved.

// File: rtl/ptx_pkg.sv
package ptx_pkg;

    localparam int BYTE_W    = 8;
    localparam int WORD_W    = 16;
    localparam int NUM_WORDS = 4;
    localparam int SYNC_MAX  = WORD_W * NUM_WORDS;
    localparam int IDX_W     = $clog2(SYNC_MAX);
    localparam int CNT_W     = IDX_W + 1;
    localparam int BPOS_W    = $clog2(BYTE_W);
    localparam int CRC_W     = 16;
    localparam int SEED_W    = 8;
    localparam logic [CRC_W-1:0] CRC_POLY = 16'h1021;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_SYNC,
        ST_TRL,
        ST_PAY,
        ST_CRC,
        ST_FIN
    } ptx_state_e;

    // last bit index of each header field
    typedef struct packed {
        logic [CNT_W-1:0] pre_last;
        logic [CNT_W-1:0] sync_last;
        logic [CNT_W-1:0] trl_last;
    } ptx_lens_t;

    typedef struct packed {
        logic len_mode;
        logic auto_stop;
        logic crc_en;
    } ptx_mode_t;

    function automatic logic [CRC_W-1:0] crc_next(input logic [CRC_W-1:0] c, input logic b);
        logic fb;
        fb = c[CRC_W-1] ^ b;
        return fb ? ({c[CRC_W-2:0], 1'b0} ^ CRC_POLY) : {c[CRC_W-2:0], 1'b0};
    endfunction

endpackage

// File: rtl/ptx_len_decode.sv
module ptx_len_decode
    import ptx_pkg::*;
(
    input  logic [2:0] pre_code,
    input  logic [1:0] sync_code,
    input  logic [2:0] trl_code,
    output ptx_lens_t  lens
);
    always_comb begin
        lens.pre_last  = CNT_W'((int'(pre_code) + 1) * BYTE_W - 1);
        lens.sync_last = CNT_W'((int'(sync_code) + 1) * WORD_W - 1);
        lens.trl_last  = CNT_W'(4 + 2 * int'(trl_code) - 1);
    end
endmodule

// File: rtl/ptx_sync_sel.sv
module ptx_sync_sel
    import ptx_pkg::*;
#(
    parameter int W  = WORD_W,
    parameter int NW = NUM_WORDS
) (
    input  logic [NW*W-1:0]         words,
    input  logic [$clog2(NW)-1:0]   code,
    output logic [NW*W-1:0]         vec
);
    // slot 0 always carries word 0; slots 1..code carry the top words
    assign vec[W-1:0] = words[W-1:0];

    for (genvar k = 1; k < NW; k++) begin : g_slot
        logic [W-1:0] pick;
        always_comb begin
            pick = '0;
            if (k <= int'(code))
                pick = words[(NW - int'(code) + k - 1) * W +: W];
        end
        assign vec[k*W +: W] = pick;
    end
endmodule

// File: rtl/ptx_crc16.sv
module ptx_crc16
    import ptx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [SEED_W-1:0] seed,
    input  logic              step,
    input  logic              din,
    input  logic              shift,
    output logic              msb
);
    logic [CRC_W-1:0] crc_q;

    always_ff @(posedge clk) begin
        if (rst)
            crc_q <= '0;
        else if (load)
            crc_q <= {{(CRC_W-SEED_W){1'b0}}, seed};
        else if (step)
            crc_q <= crc_next(crc_q, din);
        else if (shift)
            crc_q <= {crc_q[CRC_W-2:0], 1'b0};
    end

    assign msb = crc_q[CRC_W-1];

    // R9: accumulation and read-out never overlap
    assert_crc_modes_exclusive_R9: assert property (@(posedge clk) disable iff (rst)
        !(step && shift) && !(load && (step || shift)));
endmodule

// File: rtl/pkt_tx_framer.sv
module pkt_tx_framer
    import ptx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_en,
    input  logic              tx_en,
    input  logic [2:0]        cfg_pre_len,
    input  logic [1:0]        cfg_sync_len,
    input  logic [2:0]        cfg_trl_len,
    input  logic [15:0]       cfg_sync_w0,
    input  logic [15:0]       cfg_sync_w1,
    input  logic [15:0]       cfg_sync_w2,
    input  logic [15:0]       cfg_sync_w3,
    input  logic              cfg_len_mode,
    input  logic              cfg_auto_stop,
    input  logic              cfg_crc_en,
    input  logic [7:0]        cfg_crc_seed,
    input  logic              fifo_empty,
    input  logic [7:0]        fifo_data,
    output logic              fifo_rd,
    output logic              tx_bit,
    output logic              tx_valid,
    output logic              pkt_busy,
    output logic              pkt_done
);
    ptx_lens_t             lens;
    ptx_mode_t             mode;
    logic [SYNC_MAX-1:0]   sync_vec;
    logic                  crc_msb;

    ptx_state_e            state_q, state_d;
    logic [CNT_W-1:0]      cnt_q, cnt_d;
    logic [BPOS_W-1:0]     bpos_q, bpos_d;
    logic [BYTE_W-2:0]     sh_q, sh_d;
    logic [BYTE_W-1:0]     len_q, len_d, sent_q, sent_d;
    logic                  seen_q, seen_d;
    logic                  valid_q, bit_q, done_q;

    logic                  emit, ebit, pop, crc_load, crc_step, crc_shift, fin;
    logic                  end_pay;
    logic [BYTE_W-1:0]     byte_in;

    assign mode = '{len_mode: cfg_len_mode, auto_stop: cfg_auto_stop, crc_en: cfg_crc_en};

    ptx_len_decode u_len (
        .pre_code  (cfg_pre_len),
        .sync_code (cfg_sync_len),
        .trl_code  (cfg_trl_len),
        .lens      (lens)
    );

    ptx_sync_sel #(.W(WORD_W), .NW(NUM_WORDS)) u_sync (
        .words (({cfg_sync_w3, cfg_sync_w2, cfg_sync_w1, cfg_sync_w0})),
        .code  (cfg_sync_len),
        .vec   (sync_vec)
    );

    ptx_crc16 u_crc (
        .clk   (clk),
        .rst   (rst),
        .load  (crc_load),
        .seed  (cfg_crc_seed),
        .step  (crc_step),
        .din   (ebit),
        .shift (crc_shift),
        .msb   (crc_msb)
    );

    assign byte_in = fifo_empty ? '0 : fifo_data;

    always_comb begin
        if (mode.len_mode)
            end_pay = seen_q && (sent_q == len_q);
        else if (mode.auto_stop)
            end_pay = fifo_empty;
        else
            end_pay = !tx_en;
    end

    always_comb begin
        state_d   = state_q;
        cnt_d     = cnt_q;
        bpos_d    = bpos_q;
        sh_d      = sh_q;
        len_d     = len_q;
        sent_d    = sent_q;
        seen_d    = seen_q;
        emit      = 1'b0;
        ebit      = 1'b0;
        pop       = 1'b0;
        crc_load  = 1'b0;
        crc_step  = 1'b0;
        crc_shift = 1'b0;
        fin       = 1'b0;

        unique case (state_q)
            ST_IDLE: begin
                if (tx_en) begin
                    state_d  = ST_PRE;
                    cnt_d    = '0;
                    bpos_d   = '0;
                    sent_d   = '0;
                    seen_d   = 1'b0;
                    crc_load = 1'b1;
                end
            end
            ST_PRE: begin
                if (bit_en) begin
                    emit = 1'b1;
                    ebit = ~cnt_q[0];
                    if (cnt_q == lens.pre_last) begin
                        state_d = ST_SYNC;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            ST_SYNC: begin
                if (bit_en) begin
                    emit = 1'b1;
                    ebit = sync_vec[cnt_q[IDX_W-1:0]];
                    if (cnt_q == lens.sync_last) begin
                        state_d = ST_TRL;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            ST_TRL: begin
                if (bit_en) begin
                    emit = 1'b1;
                    ebit = ~cnt_q[0];
                    if (cnt_q == lens.trl_last) begin
                        state_d = ST_PAY;
                        cnt_d   = '0;
                        bpos_d  = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            ST_PAY: begin
                if (bit_en) begin
                    if (bpos_q == '0) begin
                        if (end_pay) begin
                            if (mode.crc_en) begin
                                emit      = 1'b1;
                                ebit      = crc_msb;
                                crc_shift = 1'b1;
                                state_d   = ST_CRC;
                                cnt_d     = CNT_W'(1);
                            end else begin
                                state_d = ST_FIN;
                                fin     = 1'b1;
                            end
                        end else if (!(fifo_empty && mode.len_mode)) begin
                            emit     = 1'b1;
                            ebit     = byte_in[0];
                            pop      = !fifo_empty;
                            crc_step = 1'b1;
                            sh_d     = byte_in[BYTE_W-1:1];
                            bpos_d   = BPOS_W'(1);
                            if (mode.len_mode && !seen_q) begin
                                len_d  = byte_in;
                                seen_d = 1'b1;
                            end else begin
                                sent_d = sent_q + 1'b1;
                            end
                        end
                    end else begin
                        emit     = 1'b1;
                        ebit     = sh_q[0];
                        crc_step = 1'b1;
                        sh_d     = {1'b0, sh_q[BYTE_W-2:1]};
                        bpos_d   = bpos_q + 1'b1;
                    end
                end
            end
            ST_CRC: begin
                if (bit_en) begin
                    emit      = 1'b1;
                    ebit      = crc_msb;
                    crc_shift = 1'b1;
                    if (cnt_q == CNT_W'(CRC_W - 1)) begin
                        state_d = ST_FIN;
                        fin     = 1'b1;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            ST_FIN: begin
                if (!tx_en)
                    state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            bpos_q  <= '0;
            sh_q    <= '0;
            len_q   <= '0;
            sent_q  <= '0;
            seen_q  <= 1'b0;
            valid_q <= 1'b0;
            bit_q   <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            bpos_q  <= bpos_d;
            sh_q    <= sh_d;
            len_q   <= len_d;
            sent_q  <= sent_d;
            seen_q  <= seen_d;
            valid_q <= emit;
            bit_q   <= emit & ebit;
            done_q  <= fin;
        end
    end

    assign fifo_rd  = pop;
    assign tx_bit   = bit_q;
    assign tx_valid = valid_q;
    assign pkt_done = done_q;
    assign pkt_busy = (state_q != ST_IDLE) && (state_q != ST_FIN);

    // R5: a pop never targets an empty FIFO
    assert_pop_not_empty_R5: assert property (@(posedge clk) disable iff (rst)
        fifo_rd |-> !fifo_empty);

    // R10: a valid bit only follows an enabled cycle
    assert_valid_after_enable_R10: assert property (@(posedge clk) disable iff (rst)
        tx_valid |-> $past(bit_en));

    // R11: done is a single pulse and closes a busy interval
    assert_done_single_R11: assert property (@(posedge clk) disable iff (rst)
        pkt_done |=> !pkt_done);

    assert_done_ends_busy_R11: assert property (@(posedge clk) disable iff (rst)
        pkt_done |-> (!pkt_busy && $past(pkt_busy)));

    // R12: with tx_en still high after done, the framer stays quiet
    assert_no_restart_R12: assert property (@(posedge clk) disable iff (rst)
        (pkt_done && tx_en) |=> !pkt_busy);
endmodule

// File: tb/sim_pkt_tx_framer.sv
module sim_pkt_tx_framer;
    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic        rst = 1'b1;
    logic        bit_en = 1'b0;
    logic        tx_en = 1'b0;
    logic [2:0]  p_code = 3'd0;
    logic [1:0]  s_code = 2'd0;
    logic [2:0]  t_code = 3'd0;
    logic [15:0] w0 = 16'h0, w1 = 16'h0, w2 = 16'h0, w3 = 16'h0;
    logic        lmode = 1'b0, aterm = 1'b1, crc_on = 1'b0;
    logic [7:0]  seed = 8'h0;
    logic        fifo_empty, fifo_rd, tx_bit, tx_valid, pkt_busy, pkt_done;
    logic [7:0]  fifo_data;

    logic [7:0]  fmem [0:255];
    int          rd_p = 0, wr_p = 0;
    assign fifo_empty = (rd_p == wr_p);
    assign fifo_data  = fmem[rd_p % 256];

    always @(posedge clk) if (fifo_rd && !fifo_empty) rd_p <= rd_p + 1;

    int en_div = 1, en_ph = 0;
    always @(negedge clk) begin
        if (en_div == 0) bit_en <= 1'b0;
        else begin
            bit_en <= (en_ph == 0);
            en_ph  <= (en_ph + 1 >= en_div) ? 0 : en_ph + 1;
        end
    end

    int   cyc = 0;
    logic en_at_edge = 1'b0;
    always @(posedge clk) begin
        cyc        <= cyc + 1;
        en_at_edge <= bit_en;
    end

    bit got [0:4095];
    bit expb [0:4095];
    int got_n = 0, exp_n = 0, done_cnt = 0, gap_err = 0;
    int last_valid_cyc = 0, done_cyc = -1;
    always @(negedge clk) begin
        if (tx_valid) begin
            got[got_n] = tx_bit;
            got_n = got_n + 1;
            last_valid_cyc = cyc;
            if (!en_at_edge) gap_err = gap_err + 1;
        end
        if (pkt_done) begin
            done_cnt = done_cnt + 1;
            done_cyc = cyc;
        end
    end

    pkt_tx_framer u0 (
        .clk(clk), .rst(rst), .bit_en(bit_en), .tx_en(tx_en),
        .cfg_pre_len(p_code), .cfg_sync_len(s_code), .cfg_trl_len(t_code),
        .cfg_sync_w0(w0), .cfg_sync_w1(w1), .cfg_sync_w2(w2), .cfg_sync_w3(w3),
        .cfg_len_mode(lmode), .cfg_auto_stop(aterm), .cfg_crc_en(crc_on),
        .cfg_crc_seed(seed), .fifo_empty(fifo_empty), .fifo_data(fifo_data),
        .fifo_rd(fifo_rd), .tx_bit(tx_bit), .tx_valid(tx_valid),
        .pkt_busy(pkt_busy), .pkt_done(pkt_done)
    );

    int n_chk = 0, n_err = 0;
    logic [7:0] pay [0:63];

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic push(input logic [7:0] b);
        fmem[wr_p % 256] = b;
        wr_p = wr_p + 1;
    endtask

    task automatic flush();
        wr_p = rd_p;
    endtask

    function automatic int hdr_bits();
        return 8 * (int'(p_code) + 1) + 16 * (int'(s_code) + 1) + 4 + 2 * int'(t_code);
    endfunction

    task automatic add(input bit b);
        expb[exp_n] = b;
        exp_n++;
    endtask

    // expected stream from the requirements: R2, R3, R4, R5, R9
    task automatic build_exp(input int nbytes);
        logic [63:0] v;
        logic [15:0] c;
        bit b, fb;
        exp_n = 0;
        for (int i = 0; i < 8 * (int'(p_code) + 1); i++) add(i % 2 == 0);
        case (s_code)
            2'd0: v = {48'h0, w0};
            2'd1: v = {32'h0, w3, w0};
            2'd2: v = {16'h0, w3, w2, w0};
            default: v = {w3, w2, w1, w0};
        endcase
        for (int i = 0; i < 16 * (int'(s_code) + 1); i++) add(v[i]);
        for (int i = 0; i < 4 + 2 * int'(t_code); i++) add(i % 2 == 0);
        c = {8'h00, seed};
        for (int k = 0; k < nbytes; k++)
            for (int i = 0; i < 8; i++) begin
                b  = pay[k][i];
                add(b);
                fb = c[15] ^ b;
                c  = {c[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0000);
            end
        if (crc_on) for (int i = 15; i >= 0; i--) add(c[i]);
    endtask

    task automatic compare(input string req);
        int mm;
        mm = -1;
        chk(got_n == exp_n, req, "serial bit count", got_n, exp_n);
        for (int i = 0; i < got_n && i < exp_n; i++)
            if (mm < 0 && got[i] != expb[i]) mm = i;
        chk(mm < 0, req, "first mismatching bit index", mm, -1);
    endtask

    task automatic start_pkt();
        got_n = 0; done_cnt = 0; gap_err = 0; done_cyc = -1;
        tx_en = 1'b1;
    endtask

    task automatic wait_done(input int limit);
        int k;
        k = 0;
        while (done_cnt == 0 && k < limit) begin
            @(negedge clk);
            k++;
        end
        chk(done_cnt != 0, "R11", "packet finished within limit", done_cnt, 1);
    endtask

    task automatic finish_pkt();
        tx_en = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        rst = 1'b1;
        repeat (4) @(negedge clk);
        chk(!tx_valid && !pkt_busy && !pkt_done && !fifo_rd, "R1", "outputs during reset",
            {tx_valid, pkt_busy, pkt_done, fifo_rd}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!tx_valid && !pkt_busy && !pkt_done && !fifo_rd, "R1", "outputs after reset",
            {tx_valid, pkt_busy, pkt_done, fifo_rd}, 0);
    endtask

    task automatic t_auto_basic();
        int snap;
        p_code = 3'd1; s_code = 2'd0; t_code = 3'd0; w0 = 16'hA5C3;
        lmode = 0; aterm = 1; crc_on = 1; seed = 8'h5A; en_div = 1;
        pay[0] = 8'h81; pay[1] = 8'h3C; pay[2] = 8'hF0;
        for (int i = 0; i < 3; i++) push(pay[i]);
        start_pkt();
        wait_done(2000);
        chk(last_valid_cyc == done_cyc, "R11", "done cycle vs final CRC bit cycle",
            done_cyc, last_valid_cyc);
        snap = got_n;
        repeat (20) @(negedge clk);
        chk(!pkt_busy && got_n == snap && done_cnt == 1, "R12", "no restart while tx_en held",
            got_n, snap);
        finish_pkt();
        build_exp(3);
        compare("R2 R3 R4 R5 R7 R9");
        chk(rd_p == wr_p, "R5", "bytes left in FIFO", wr_p - rd_p, 0);
    endtask

    task automatic t_sync_lengths();
        w0 = 16'h1234; w1 = 16'h5678; w2 = 16'h9ABC; w3 = 16'hDEF1;
        lmode = 0; aterm = 1; crc_on = 0; en_div = 3;
        for (int s = 1; s < 4; s++) begin
            s_code = 2'(s); p_code = 3'(s); t_code = 3'(s + 2);
            pay[0] = 8'(8'h4B + s);
            push(pay[0]);
            start_pkt();
            wait_done(4000);
            finish_pkt();
            build_exp(1);
            compare("R3 R4");
            chk(gap_err == 0, "R10", "valid bits without prior enable", gap_err, 0);
        end
    endtask

    task automatic t_enable_hold();
        p_code = 0; s_code = 0; t_code = 0; w0 = 16'h0F0F;
        lmode = 0; aterm = 1; crc_on = 0; en_div = 0;
        pay[0] = 8'hC6;
        push(pay[0]);
        start_pkt();
        repeat (30) @(negedge clk);
        chk(got_n == 0 && pkt_busy, "R10", "bits sent while enable held low", got_n, 0);
        en_div = 1;
        wait_done(2000);
        finish_pkt();
        build_exp(1);
        compare("R10");
    endtask

    task automatic t_len_mode();
        p_code = 0; s_code = 3; t_code = 7;
        w0 = 16'hCAFE; w1 = 16'hBEEF; w2 = 16'h0123; w3 = 16'h4567;
        lmode = 1; aterm = 0; crc_on = 1; seed = 8'h3C; en_div = 1;
        pay[0] = 8'd3; pay[1] = 8'h12; pay[2] = 8'h34; pay[3] = 8'h56;
        for (int i = 0; i < 4; i++) push(pay[i]);
        push(8'h99);
        start_pkt();
        wait_done(3000);
        finish_pkt();
        build_exp(4);
        compare("R6 R9");
        chk(wr_p - rd_p == 1, "R6", "bytes left after length reached", wr_p - rd_p, 1);
        flush();
        pay[0] = 8'd0;
        push(pay[0]); push(8'hEE);
        start_pkt();
        wait_done(3000);
        finish_pkt();
        build_exp(1);
        compare("R6");
        chk(wr_p - rd_p == 1, "R6", "bytes left after zero length", wr_p - rd_p, 1);
        flush();
    endtask

    task automatic t_len_stall();
        p_code = 0; s_code = 0; t_code = 0; w0 = 16'h5AA5;
        lmode = 1; crc_on = 0; en_div = 1;
        start_pkt();
        repeat (hdr_bits() + 40) @(negedge clk);
        chk(got_n == hdr_bits() && pkt_busy, "R6", "bits sent while FIFO starved",
            got_n, hdr_bits());
        pay[0] = 8'd1; pay[1] = 8'h77;
        push(pay[0]); push(pay[1]);
        wait_done(2000);
        finish_pkt();
        build_exp(2);
        compare("R6");
    endtask

    task automatic t_manual();
        int nb;
        p_code = 0; s_code = 1; t_code = 1; w0 = 16'h1357; w3 = 16'h2468;
        lmode = 0; aterm = 0; crc_on = 1; seed = 8'h81; en_div = 1;
        pay[0] = 8'h11;
        push(pay[0]);
        start_pkt();
        repeat (hdr_bits() + 40) @(negedge clk);
        tx_en = 1'b0;
        wait_done(2000);
        repeat (3) @(negedge clk);
        nb = got_n - hdr_bits() - 16;
        chk(nb % 8 == 0 && nb >= 16, "R8", "payload bits with filler", nb, 40);
        for (int i = 1; i < 64; i++) pay[i] = 8'h00;
        build_exp(nb / 8);
        compare("R8 R9");
        chk(rd_p == wr_p, "R8", "FIFO drained without extra pops", wr_p - rd_p, 0);
    endtask

    task automatic t_auto_empty();
        p_code = 2; s_code = 0; t_code = 2; w0 = 16'h8001;
        lmode = 0; aterm = 1; crc_on = 1; seed = 8'h00; en_div = 2;
        start_pkt();
        wait_done(2000);
        finish_pkt();
        build_exp(0);
        compare("R7 R9");
        crc_on = 0;
        start_pkt();
        wait_done(2000);
        finish_pkt();
        build_exp(0);
        compare("R7 R9");
        chk(done_cnt == 1, "R11", "done pulses per packet", done_cnt, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_auto_basic();
        t_sync_lengths();
        t_enable_hold();
        t_len_mode();
        t_len_stall();
        t_manual();
        t_auto_empty();
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule